// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single capture/compare lane of a general-purpose timer. The timer core supplies the running count, the reload limit, the counting direction and one-cycle pulses that mark wrap-around at the top (overflow) and at zero (underflow). The lane holds one value register. A mode input selects how it is used. In compare mode the lane raises a sticky event flag when the count reaches the stored value. In capture mode an edge on an external input copies the count into that register.

In compare mode, a stored value above the reload limit can never be reached by the count. In that case the flag is raised by the wrap pulse instead: overflow when counting up or centre-aligned, underflow when counting down. In capture mode the external input passes through a synchroniser and an edge selector. A capture raises the event flag. A capture that lands while the flag is still set also raises an overcapture flag, and the new count replaces the old one. Reading the register while in capture mode acknowledges the event flag. A parameter builds a compare-only lane, which has no capture path at all.

Top module: `tmr_ccx_channel`

## Requirements
- R1: While reset is active, and directly after it, the stored value reads 0 and both flags are 0.
- R2: In compare mode, when the count equals the stored value on a clock edge, the event flag is 1 after that edge.
- R3: In compare mode, with the stored value greater than the reload limit, an overflow pulse sets the event flag when cnt_mode_i is 00 (up), 10 or 11 (centre-aligned). An underflow pulse sets it when cnt_mode_i is 01 (down). The other pulse has no effect.
- R4: In capture mode, an input transition of the selected kind sets the event flag and loads the count. This happens on the third rising clock edge after the transition, and not before it. The pol_i encoding is 00 rising, 01 falling, 11 both, and 10 behaves as rising. Transitions of any other kind are ignored.
- R5: In capture mode, a read strobe clears the event flag on the next edge. In compare mode a read strobe leaves the flag unchanged.
- R6: A capture while the event flag is already 1 sets the overcapture flag and overwrites the stored value. The overcapture flag can only become 1 in capture mode.
- R7: In compare mode, a write strobe loads the stored value, which reads back after the next edge. In capture mode, write strobes leave the stored value unchanged.
- R8: clr_flag_i clears the event flag and clr_ovc_i clears the overcapture flag, each without touching the other flag. A set condition in the same cycle wins over a clear.
- R9: With HAS_INPUT = 0 the lane ignores mode_in_i and always behaves in compare mode: it accepts writes, and its overcapture flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Running counter value |
| arr_i | input | CNT_W | Reload limit of the counter |
| cnt_mode_i | input | 2 | 00 up, 01 down, 10/11 centre-aligned |
| ovf_i | input | 1 | One-cycle overflow pulse |
| unf_i | input | 1 | One-cycle underflow pulse |
| mode_in_i | input | 1 | 1 selects capture mode, 0 compare mode |
| pol_i | input | 2 | Capture edge select |
| cap_in_i | input | 1 | Asynchronous capture input |
| reg_wr_i | input | 1 | Write strobe for the stored value |
| reg_rd_i | input | 1 | Read strobe (acknowledge) |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Stored value |
| clr_flag_i | input | 1 | Clear the event flag |
| clr_ovc_i | input | 1 | Clear the overcapture flag |
| cc_flag_o | output | 1 | Event flag |
| ovc_flag_o | output | 1 | Overcapture flag |

## Verification
The hardest state to reach is overcapture. It needs a second qualified edge to get through the three-stage input path while the first capture is still unacknowledged. It also needs the edge selector to be set so that the second transition counts. The stimulus gets there with directed sequences. These switch the polarity to both-edges after one capture, so that the return transition of the input triggers the second capture. The wrap-based compare path is covered by a fixed-seed random phase. That phase holds small counts, limits and stored values, so matches, out-of-range values and wrap pulses all occur often.

// File: rtl/tmr_ccx_pkg.sv
package tmr_ccx_pkg;

   typedef enum logic [1:0] {
      CM_UP    = 2'b00,
      CM_DOWN  = 2'b01,
      CM_CTR_A = 2'b10,
      CM_CTR_B = 2'b11
   } cnt_mode_e;

   typedef enum logic [1:0] {
      POL_RISE = 2'b00,
      POL_FALL = 2'b01,
      POL_RSVD = 2'b10,
      POL_BOTH = 2'b11
   } edge_pol_e;

   // Edge qualification; the reserved code falls back to rising.
   function automatic logic edge_qualify(input logic [1:0] pol,
                                         input logic rise,
                                         input logic fall);
      logic hit;
      case (edge_pol_e'(pol))
         POL_FALL: hit = fall;
         POL_BOTH: hit = rise | fall;
         default:  hit = rise;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/ccx_edge_sync.sv
module ccx_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       async_i,
   input  logic [1:0] pol_i,
   output logic       edge_o
);
   import tmr_ccx_pkg::*;

   if (STAGES < 2) begin : g_bad_stages
      $error("ccx_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              rise, fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise   = sync_q[STAGES-1] & ~prev_q;
   assign fall   = ~sync_q[STAGES-1] & prev_q;
   assign edge_o = edge_qualify(pol_i, rise, fall);

endmodule

// File: rtl/ccx_cmp_match.sv
module ccx_cmp_match #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] arr_i,
   input  logic [CNT_W-1:0] ccr_i,
   input  logic [1:0]       cnt_mode_i,
   input  logic             ovf_i,
   input  logic             unf_i,
   output logic             hit_o
);
   import tmr_ccx_pkg::*;

   logic out_of_range;
   logic wrap_hit;

   assign out_of_range = (ccr_i > arr_i);

   always_comb begin
      case (cnt_mode_e'(cnt_mode_i))
         CM_DOWN: wrap_hit = unf_i;
         default: wrap_hit = ovf_i;
      endcase
   end

   assign hit_o = (cnt_i == ccr_i) | (out_of_range & wrap_hit);

endmodule

// File: rtl/tmr_ccx_channel.sv
module tmr_ccx_channel #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_INPUT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] arr_i,
   input  logic [1:0]       cnt_mode_i,
   input  logic             ovf_i,
   input  logic             unf_i,
   input  logic             mode_in_i,
   input  logic [1:0]       pol_i,
   input  logic             cap_in_i,
   input  logic             reg_wr_i,
   input  logic             reg_rd_i,
   input  logic [CNT_W-1:0] reg_wdata_i,
   output logic [CNT_W-1:0] reg_rdata_o,
   input  logic             clr_flag_i,
   input  logic             clr_ovc_i,
   output logic             cc_flag_o,
   output logic             ovc_flag_o
);

   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
      $error("tmr_ccx_channel: CNT_W must lie in 2..64");
   end

   logic [CNT_W-1:0] ccr_q;
   logic             cc_q, ovc_q;
   logic             eff_in;
   logic             cap_evt;
   logic             cmp_hit;
   logic             cc_set, cc_clr, ovc_set;

   // Capture path: only present in a lane built with an input stage.
   if (HAS_INPUT) begin : g_cap
      logic edge_hit;
      ccx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .async_i(cap_in_i),
         .pol_i  (pol_i),
         .edge_o (edge_hit)
      );
      assign eff_in  = mode_in_i;
      assign cap_evt = mode_in_i & edge_hit;
   end else begin : g_nocap
      assign eff_in  = 1'b0;
      assign cap_evt = 1'b0;
   end

   ccx_cmp_match #(.CNT_W(CNT_W)) u_cmp (
      .cnt_i     (cnt_i),
      .arr_i     (arr_i),
      .ccr_i     (ccr_q),
      .cnt_mode_i(cnt_mode_i),
      .ovf_i     (ovf_i),
      .unf_i     (unf_i),
      .hit_o     (cmp_hit)
   );

   assign cc_set  = (~eff_in & cmp_hit) | cap_evt;
   assign cc_clr  = clr_flag_i | (eff_in & reg_rd_i);
   assign ovc_set = cap_evt & cc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ccr_q <= '0;
         cc_q  <= 1'b0;
         ovc_q <= 1'b0;
      end else begin
         if (cap_evt)
            ccr_q <= cnt_i;
         else if (reg_wr_i && !eff_in)
            ccr_q <= reg_wdata_i;

         if (cc_set)
            cc_q <= 1'b1;
         else if (cc_clr)
            cc_q <= 1'b0;

         if (ovc_set)
            ovc_q <= 1'b1;
         else if (clr_ovc_i)
            ovc_q <= 1'b0;
      end
   end

   assign reg_rdata_o = ccr_q;
   assign cc_flag_o   = cc_q;
   assign ovc_flag_o  = ovc_q;

   // ---------------------------------------------------------------
   // Assertions
   // ---------------------------------------------------------------
   assert_cmp_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!eff_in && cnt_i == reg_rdata_o) |=> cc_flag_o);

   assert_wrap_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!eff_in && reg_rdata_o > arr_i && ovf_i && cnt_mode_i != 2'b01) |=> cc_flag_o);

   assert_capture_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (cc_flag_o && reg_rdata_o == $past(cnt_i)));

   assert_read_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_in && reg_rd_i && !cap_evt) |=> !cc_flag_o);

   assert_overcap_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && cc_flag_o) |=> ovc_flag_o);

   assert_overcap_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovc_flag_o) |-> $past(eff_in));

   assert_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_in && !cap_evt) |=> $stable(reg_rdata_o));

endmodule

// File: tb/tb_tmr_ccx_channel.sv
module tb_tmr_ccx_channel;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] cnt = '0, arr = '0, wdata = '0;
   logic [1:0] cmode = 2'b00, pol = 2'b00;
   logic ovf = 0, unf = 0, imode = 1, cap = 0, wr = 0, rd = 0, clr_f = 0, clr_o = 0;
   logic [W-1:0] rdata, rdata2;
   logic flag, ovc, flag2, ovc2;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   tmr_ccx_channel #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .arr_i(arr), .cnt_mode_i(cmode),
      .ovf_i(ovf), .unf_i(unf), .mode_in_i(imode), .pol_i(pol), .cap_in_i(cap),
      .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .clr_flag_i(clr_f), .clr_ovc_i(clr_o), .cc_flag_o(flag), .ovc_flag_o(ovc));

   tmr_ccx_channel #(.CNT_W(W), .HAS_INPUT(1'b0)) dut_co (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .arr_i(arr), .cnt_mode_i(cmode),
      .ovf_i(ovf), .unf_i(unf), .mode_in_i(imode), .pol_i(pol), .cap_in_i(cap),
      .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata2),
      .clr_flag_i(clr_f), .clr_ovc_i(clr_o), .cc_flag_o(flag2), .ovc_flag_o(ovc2));

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reference for compare mode, derived from R2, R3, R8.
   function automatic logic model_flag(input logic cur, input logic [W-1:0] ccr,
                                       input logic [W-1:0] c, input logic [W-1:0] a,
                                       input logic [1:0] m, input logic o, input logic u,
                                       input logic clr);
      logic wrap;
      wrap = (m == 2'b01) ? u : o;
      if (c == ccr || (ccr > a && wrap)) return 1'b1;
      if (clr) return 1'b0;
      return cur;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [W-1:0] exp_ccr;
      logic exp_flag;
      void'($urandom(32'd2024));
      cnt = 16'h0010;
      @(negedge clk);
      tick(2);
      // R1: reset state
      chk("R1 flag", flag, 0);
      chk("R1 ovc", ovc, 0);
      chk("R1 value", rdata, 0);
      rst_n = 1'b1;
      tick(4);
      chk("R1 after release", {ovc, flag}, 0);

      // R4: rising capture, latency of three edges
      cnt = 16'h1234; cap = 1;
      tick(2);
      chk("R4 latency", flag, 0);
      tick(1);
      chk("R4 flag", flag, 1);
      chk("R4 value", rdata, 16'h1234);

      // R5: read in capture mode acknowledges
      rd = 1; tick(1); rd = 0;
      chk("R5 read clear", flag, 0);

      // R4: falling transition ignored with rising select
      cap = 0; cnt = 16'h2222; tick(4);
      chk("R4 wrong edge flag", flag, 0);
      chk("R4 wrong edge value", rdata, 16'h1234);

      // R4: falling select
      pol = 2'b01; cap = 1; tick(4);
      chk("R4 fall sel ignores rise", flag, 0);
      cap = 0; cnt = 16'h0AAA; tick(3);
      chk("R4 fall flag", flag, 1);
      chk("R4 fall value", rdata, 16'h0AAA);
      chk("R6 no overcapture yet", ovc, 0);

      // R6: overcapture with both-edge select
      pol = 2'b11; cap = 1; cnt = 16'h0BBB; tick(3);
      chk("R6 overcapture", ovc, 1);
      chk("R6 overwrite", rdata, 16'h0BBB);
      chk("R9 no overcapture", ovc2, 0);

      // R7 / R9: write ignored in capture mode, accepted by compare-only lane
      wr = 1; wdata = 16'h5555; tick(1); wr = 0;
      chk("R7 write ignored", rdata, 16'h0BBB);
      chk("R9 write accepted", rdata2, 16'h5555);

      // R8: clear overcapture only
      clr_o = 1; tick(1); clr_o = 0;
      chk("R8 ovc cleared", ovc, 0);
      chk("R8 flag kept", flag, 1);

      // R4: reserved code behaves as rising
      rd = 1; tick(1); rd = 0;
      pol = 2'b10; cap = 0; tick(4);
      chk("R4 reserved ignores fall", flag, 0);
      cap = 1; cnt = 16'h0CCC; tick(3);
      chk("R4 reserved rise", flag, 1);
      chk("R4 reserved value", rdata, 16'h0CCC);

      // Compare mode directed
      cnt = 16'h0000; imode = 0; tick(1);
      clr_f = 1; tick(1); clr_f = 0;
      chk("R8 flag cleared", flag, 0);
      wr = 1; wdata = 16'h0005; tick(1); wr = 0;
      chk("R7 write readback", rdata, 16'h0005);
      cnt = 16'h0005; tick(1);
      chk("R2 match", flag, 1);
      cnt = 16'h0006; rd = 1; tick(1); rd = 0;
      chk("R5 read in compare mode", flag, 1);
      clr_f = 1; tick(1);
      chk("R8 clear", flag, 0);
      cnt = 16'h0005; tick(1); clr_f = 0;
      chk("R8 set beats clear", flag, 1);

      // R3: out-of-range value, wrap pulses
      cnt = 16'h0000; arr = 16'h0003;
      clr_f = 1; tick(1); clr_f = 0;
      cmode = 2'b00; ovf = 1; tick(1); ovf = 0;
      chk("R3 up overflow", flag, 1);
      clr_f = 1; tick(1); clr_f = 0;
      cmode = 2'b01; ovf = 1; tick(1); ovf = 0;
      chk("R3 down ignores overflow", flag, 0);
      unf = 1; tick(1); unf = 0;
      chk("R3 down underflow", flag, 1);
      clr_f = 1; tick(1); clr_f = 0;
      cmode = 2'b10; unf = 1; tick(1); unf = 0;
      chk("R3 centre ignores underflow", flag, 0);
      ovf = 1; tick(1); ovf = 0;
      chk("R3 centre overflow", flag, 1);

      // Random compare-mode phase
      cnt = 16'h0007; wr = 1; wdata = 16'h0003; clr_f = 1; tick(1);
      wr = 0; clr_f = 0;
      exp_ccr = 16'h0003; exp_flag = 0;
      chk("R8 random start", flag, 0);
      for (int k = 0; k < 400; k++) begin
         cnt   = W'($urandom_range(0, 7));
         arr   = W'($urandom_range(0, 7));
         cmode = 2'($urandom_range(0, 3));
         ovf   = ($urandom_range(0, 5) == 0);
         unf   = ($urandom_range(0, 5) == 0);
         clr_f = ($urandom_range(0, 2) == 0);
         rd    = ($urandom_range(0, 3) == 0);
         wr    = ($urandom_range(0, 4) == 0);
         wdata = W'($urandom_range(0, 9));
         exp_flag = model_flag(exp_flag, exp_ccr, cnt, arr, cmode, ovf, unf, clr_f);
         if (wr) exp_ccr = wdata;
         tick(1);
         chk("R2/R3 random flag", flag, exp_flag);
         chk("R7 random value", rdata, exp_ccr);
         chk("R6 random ovc", ovc, 0);
      end
      ovf = 0; unf = 0; clr_f = 0; rd = 0; wr = 0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule